// File: doc/BRIEF.md
# Bidirectional Handshake Port Controller

This block drives one eight-bit port that sends and receives over the same eight wires. A typical use is a parallel link between two computers. It keeps two separate latches. The output latch is loaded by a host write and goes onto the shared pads only while the far side holds its active-low acknowledge pin low. The input latch captures the pads when the far side pulls its active-low strobe pin low.

Each direction has a buffer-full flag. Both directions share one interrupt line, and each direction has its own enable bit to gate its part of that line. The enable bits sit in a control image that the host changes through single-bit set/clear commands. The three lowest bits of that image drive general-purpose pins.

The host interface has four register slots, selected by a two-bit address:

- Address 0 is the data register.
- Address 1 is the status register.
- Address 2 is the command register.
- Address 3 is unused.

Host reads are combinational. Every update takes effect on the rising clock edge. The strobe and acknowledge pins are sampled on each rising edge, and their edges are found by comparing each sample with the previous one.

Top module: `bidir_hs_port`

## Requirements
- R1: After reset the block shows the following: `obf_n` = 1, `ibf` = 0, `intr` = 0, `gp_out` = 0, and `pad_oe` = 0 while `ack_n` is high.
- R2: `pad_oe` is 1 exactly while `ack_n` is low. `pad_out` always shows the output latch.
- R3: A host write to address 0 loads `host_wdata` into the output latch. After that edge, `obf_n` reads 0.
- R4: A falling edge on `ack_n` sets `obf_n` to 1 after the edge. A falling edge is a sample of 1 followed by a sample of 0. If a host write to address 0 falls in the same cycle, the write wins and `obf_n` stays 0.
- R5: A falling edge on `stb_n` has these effects after the edge:
  - `pad_in` is copied into the input latch.
  - `ibf` becomes 1.
  - Later changes on `pad_in` while `stb_n` stays low do not alter the latch.
- R6: A host read of address 0 returns the input latch in the same cycle and clears `ibf` after the edge. If a strobe capture falls in the same cycle, the capture wins and `ibf` stays 1.
- R7: A write to address 2 with bit 7 = 0 is a bit command: bit `wdata[3:1]` of the control image takes the value `wdata[0]`. A write to address 2 with bit 7 = 1 is ignored. `gp_out` equals control bits 2:0.
- R8: The input-side pending flag sets on a rising edge of `stb_n` while `ibf` is 1, and clears on a host read of address 0. Its share of `intr` is gated by control bit 4.
- R9: The output-side pending flag sets on a rising edge of `ack_n`, and clears on a host write of address 0. Its share of `intr` is gated by control bit 6. `intr` is the OR of both gated shares.
- R10: A read of address 1 returns the following, with all other bits 0:
  - bit 0: `ibf`
  - bit 1: output full
  - bit 2: control bit 4
  - bit 3: control bit 6

  A read of address 2 returns control bits 6, 4 and 2:0, with all other bits 0.
- R11: Writes to addresses 1 and 3 change nothing. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_cs | input | 1 | Host access valid this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register slot |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data (combinational) |
| pad_out | output | DATA_W | Output latch towards the pads |
| pad_oe | output | 1 | Pad driver enable |
| pad_in | input | DATA_W | Value seen on the pads |
| stb_n | input | 1 | Far-side strobe, active low |
| ack_n | input | 1 | Far-side acknowledge, active low |
| ibf | output | 1 | Input latch holds unread data |
| obf_n | output | 1 | Output latch not yet taken, active low |
| intr | output | 1 | Merged interrupt request |
| gp_out | output | GP_W | General-purpose control pins |

## Verification
Each result of this block has a fixed due cycle:

- `pad_oe` and `host_rdata` follow their inputs within the same cycle. The bench checks them 1 ns after driving, before the next rising edge.
- Flags, latches, pending bits, `intr` and `gp_out` change on the first rising edge that samples the causing write, read, strobe edge or acknowledge edge. An edge on a pin counts once that edge has sampled the new pin level.

The bench drives all stimulus on falling clock edges. It checks registered results at the next falling edge, exactly one rising edge later. The same-cycle collisions are driven on one edge so that the priority each one names is observed.

// File: rtl/bhp_pkg.sv
package bhp_pkg;
    typedef enum logic [1:0] {
        SLOT_DATA = 2'd0,
        SLOT_STAT = 2'd1,
        SLOT_CMD  = 2'd2,
        SLOT_NONE = 2'd3
    } slot_e;

    localparam int EN_OUT_BIT = 6;
    localparam int EN_IN_BIT  = 4;
    localparam int CMD_FLAG   = 7;
endpackage

// File: rtl/bhp_edge.sv
module bhp_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_n,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic prev_d, prev_q;

        always_comb prev_d = pin_n[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= prev_d;
        end

        assign fall[i] = prev_q & ~pin_n[i];
        assign rise[i] = ~prev_q & pin_n[i];
    end
endmodule

// File: rtl/bhp_bsr.sv
module bhp_bsr #(
    parameter int W = 8,
    localparam int SEL_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [SEL_W-1:0] cmd_sel,
    input  logic             cmd_val,
    output logic [W-1:0]     ctrl
);
    logic [W-1:0] ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (cmd_valid) ctrl_d[cmd_sel] = cmd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/bidir_hs_port.sv
module bidir_hs_port
    import bhp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int GP_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [DATA_W-1:0] pad_out,
    output logic              pad_oe,
    input  logic [DATA_W-1:0] pad_in,
    input  logic              stb_n,
    input  logic              ack_n,
    output logic              ibf,
    output logic              obf_n,
    output logic              intr,
    output logic [GP_W-1:0]   gp_out
);
    localparam int SEL_W  = $clog2(DATA_W);
    localparam int PIN_STB = 0;
    localparam int PIN_ACK = 1;

    typedef struct packed {
        logic [DATA_W-1:0] out_lat;
        logic [DATA_W-1:0] in_lat;
        logic              obf;
        logic              ibf;
        logic              out_pend;
        logic              in_pend;
    } port_st_t;

    port_st_t st_d, st_q;

    logic [1:0] pin_fall, pin_rise;
    logic [DATA_W-1:0] ctrl;
    logic wr_data, rd_data, cmd_wr;
    logic en_in, en_out;
    logic unused_ctrl;

    // Strobe and acknowledge edge detection
    bhp_edge #(.N(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n ({ack_n, stb_n}),
        .fall  (pin_fall),
        .rise  (pin_rise)
    );

    // Host register decode
    assign wr_data = host_cs &  host_we & (slot_e'(host_addr) == SLOT_DATA);
    assign rd_data = host_cs & ~host_we & (slot_e'(host_addr) == SLOT_DATA);
    assign cmd_wr  = host_cs &  host_we & (slot_e'(host_addr) == SLOT_CMD)
                     & ~host_wdata[CMD_FLAG];

    bhp_bsr #(.W(DATA_W)) u_bsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_wr),
        .cmd_sel   (host_wdata[SEL_W:1]),
        .cmd_val   (host_wdata[0]),
        .ctrl      (ctrl)
    );

    assign en_in       = ctrl[EN_IN_BIT];
    assign en_out      = ctrl[EN_OUT_BIT];
    assign unused_ctrl = ^ctrl;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        // Output direction: a host write beats an acknowledge fall in the same cycle
        if (pin_fall[PIN_ACK]) st_d.obf = 1'b0;
        if (wr_data) begin
            st_d.out_lat  = host_wdata;
            st_d.obf      = 1'b1;
            st_d.out_pend = 1'b0;
        end
        if (pin_rise[PIN_ACK]) st_d.out_pend = 1'b1;
        // Input direction: a strobe capture beats a host read in the same cycle
        if (rd_data) begin
            st_d.ibf     = 1'b0;
            st_d.in_pend = 1'b0;
        end
        if (pin_fall[PIN_STB]) begin
            st_d.in_lat = pad_in;
            st_d.ibf    = 1'b1;
        end
        if (pin_rise[PIN_STB] && st_q.ibf) st_d.in_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Host read mux
    always_comb begin
        host_rdata = '0;
        unique case (slot_e'(host_addr))
            SLOT_DATA: host_rdata = st_q.in_lat;
            SLOT_STAT: begin
                host_rdata[0] = st_q.ibf;
                host_rdata[1] = st_q.obf;
                host_rdata[2] = en_in;
                host_rdata[3] = en_out;
            end
            SLOT_CMD: begin
                host_rdata[EN_OUT_BIT] = en_out;
                host_rdata[EN_IN_BIT]  = en_in;
                host_rdata[GP_W-1:0]   = ctrl[GP_W-1:0];
            end
            default: host_rdata = '0;
        endcase
    end

    // Pad and flag outputs
    assign pad_out = st_q.out_lat;
    assign pad_oe  = ~ack_n;
    assign ibf     = st_q.ibf;
    assign obf_n   = ~st_q.obf;
    assign intr    = (st_q.out_pend & en_out) | (st_q.in_pend & en_in);
    assign gp_out  = ctrl[GP_W-1:0];
endmodule

// File: rtl/bhp_checker.sv
module bhp_checker #(
    parameter int DATA_W = 8,
    parameter int GP_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_cs,
    input logic              host_we,
    input logic [1:0]        host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic              stb_n,
    input logic              ack_n,
    input logic [DATA_W-1:0] pad_out,
    input logic              ibf,
    input logic              obf_n,
    input logic              intr,
    input logic [GP_W-1:0]   gp_out,
    input logic              en_in,
    input logic              en_out
);
    logic wr0, rd0, wr2;
    assign wr0 = host_cs &  host_we & (host_addr == 2'd0);
    assign rd0 = host_cs & ~host_we & (host_addr == 2'd0);
    assign wr2 = host_cs &  host_we & (host_addr == 2'd2);

    AST_WR_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wr0 |=> !obf_n); // R3
    AST_WR_LOADS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr0 |=> pad_out == $past(host_wdata)); // R2
    AST_ACK_FALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ack_n) && !ack_n && !wr0) |=> obf_n); // R4
    AST_STB_FALL_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stb_n) && !stb_n) |=> ibf); // R5
    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0 && !($past(stb_n) && !stb_n)) |=> !ibf); // R6
    AST_GP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr2 |=> $stable(gp_out)); // R7
    AST_INTR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> (en_in || en_out)); // R9
endmodule

bind bidir_hs_port bhp_checker #(.DATA_W(DATA_W), .GP_W(GP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_cs    (host_cs),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .stb_n      (stb_n),
    .ack_n      (ack_n),
    .pad_out    (pad_out),
    .ibf        (ibf),
    .obf_n      (obf_n),
    .intr       (intr),
    .gp_out     (gp_out),
    .en_in      (en_in),
    .en_out     (en_out)
);

// File: tb/bidir_hs_port_bench.sv
`timescale 1ns/100ps
module bidir_hs_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata, pad_out, pad_in = 8'h00;
    logic       pad_oe, stb_n = 1'b1, ack_n = 1'b1;
    logic       ibf, obf_n, intr;
    logic [2:0] gp_out;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    bidir_hs_port u_bidir_hs_port (
        .clk(clk), .rst_n(rst_n), .host_cs(cs), .host_we(we), .host_addr(addr),
        .host_wdata(wdata), .host_rdata(rdata), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_in(pad_in), .stb_n(stb_n), .ack_n(ack_n), .ibf(ibf), .obf_n(obf_n),
        .intr(intr), .gp_out(gp_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        cs = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic strobe(input logic [7:0] v);
        pad_in = v; stb_n = 1'b0;
        @(negedge clk);
        stb_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ack_pulse();
        ack_n = 1'b0;
        @(negedge clk);
        ack_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 obf_n", obf_n, 1);
        chk("R1 ibf", ibf, 0);
        chk("R1 intr", intr, 0);
        chk("R1 pad_oe", pad_oe, 0);
        chk("R1 gp_out", gp_out, 0);
    endtask

    task automatic t_write_ack();
        foreach (pat[i]) begin end
        bus_wr(2'd0, 8'hA5);
        chk("R3 obf_n after write", obf_n, 0);
        chk("R2 oe off while ack high", pad_oe, 0);
        ack_n = 1'b0;
        #1 chk("R2 oe on while ack low", pad_oe, 1);
        chk("R2 pad_out", pad_out, 8'hA5);
        @(negedge clk);
        chk("R4 obf_n after ack fall", obf_n, 1);
        ack_n = 1'b1;
        #1 chk("R2 oe off after ack", pad_oe, 0);
        @(negedge clk);
        bus_wr(2'd0, 8'h3C);
        chk("R3 second byte pad_out", pad_out, 8'h3C);
        chk("R3 obf_n second byte", obf_n, 0);
        ack_pulse();
        chk("R4 obf_n second ack", obf_n, 1);
    endtask
    logic [7:0] pat [2] = '{8'h5A, 8'h81};

    task automatic t_strobe();
        logic [7:0] d;
        for (int i = 0; i < 2; i++) begin
            pad_in = pat[i]; stb_n = 1'b0;
            @(negedge clk);
            chk("R5 ibf after strobe", ibf, 1);
            pad_in = ~pat[i];
            @(negedge clk);
            stb_n = 1'b1;
            @(negedge clk);
            bus_rd(2'd0, d);
            chk("R5 R6 latched byte", d, pat[i]);
            chk("R6 ibf cleared", ibf, 0);
        end
    endtask

    task automatic t_ctrl();
        logic [7:0] d;
        bus_wr(2'd2, 8'h03); chk("R7 set bit1", gp_out, 3'b010);
        bus_wr(2'd2, 8'h01); chk("R7 set bit0", gp_out, 3'b011);
        bus_wr(2'd2, 8'h05); chk("R7 set bit2", gp_out, 3'b111);
        bus_wr(2'd2, 8'h02); chk("R7 clear bit1", gp_out, 3'b101);
        bus_wr(2'd2, 8'h80); chk("R7 flagged word ignored", gp_out, 3'b101);
        bus_rd(2'd2, d);     chk("R10 control image", d, 8'h05);
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd2, 8'h04); chk("R7 cleared", gp_out, 3'b000);
    endtask

    task automatic t_intr_in();
        logic [7:0] d;
        bus_wr(2'd2, 8'h09);
        pad_in = 8'h42; stb_n = 1'b0;
        @(negedge clk);
        chk("R8 no intr before strobe rise", intr, 0);
        stb_n = 1'b1;
        @(negedge clk);
        chk("R8 intr after strobe rise", intr, 1);
        bus_rd(2'd0, d);
        chk("R8 intr cleared by read", intr, 0);
        bus_wr(2'd2, 8'h08);
        strobe(8'h17);
        chk("R8 gated off", intr, 0);
        bus_wr(2'd2, 8'h09);
        chk("R8 pending shows when enabled", intr, 1);
        bus_rd(2'd0, d);
        chk("R8 read clears", intr, 0);
        bus_wr(2'd2, 8'h08);
    endtask

    task automatic t_intr_out();
        bus_wr(2'd2, 8'h0D);
        bus_wr(2'd0, 8'h77);
        chk("R9 no intr after write", intr, 0);
        ack_n = 1'b0;
        @(negedge clk);
        chk("R9 no intr on ack fall", intr, 0);
        ack_n = 1'b1;
        @(negedge clk);
        chk("R9 intr on ack rise", intr, 1);
        bus_wr(2'd0, 8'h78);
        chk("R9 write clears pending", intr, 0);
        ack_pulse();
        chk("R9 intr again", intr, 1);
        bus_wr(2'd2, 8'h0C);
        chk("R9 gated by bit6", intr, 0);
    endtask

    task automatic t_status();
        logic [7:0] d;
        strobe(8'hC3);
        bus_wr(2'd0, 8'h99);
        bus_wr(2'd2, 8'h09);
        bus_wr(2'd2, 8'h0D);
        bus_wr(2'd2, 8'h03);
        bus_rd(2'd1, d);
        chk("R10 status all set", d, 8'h0F);
        bus_wr(2'd1, 8'hFF);
        bus_wr(2'd3, 8'h00);
        bus_rd(2'd1, d);
        chk("R11 status unchanged", d, 8'h0F);
        chk("R11 gp unchanged", gp_out, 3'b010);
        chk("R11 pad_out unchanged", pad_out, 8'h99);
        bus_rd(2'd3, d);
        chk("R11 slot 3 reads zero", d, 8'h00);
        bus_rd(2'd0, d);
        chk("R6 status byte", d, 8'hC3);
        ack_pulse();
        bus_rd(2'd1, d);
        chk("R10 status after drain", d, 8'h0C);
    endtask

    task automatic t_collision();
        logic [7:0] d;
        ack_n = 1'b0;
        bus_wr(2'd0, 8'h11);
        chk("R4 write beats ack fall", obf_n, 0);
        ack_n = 1'b1;
        @(negedge clk);
        pad_in = 8'h22; stb_n = 1'b0;
        bus_rd(2'd0, d);
        chk("R6 capture beats read", ibf, 1);
        stb_n = 1'b1;
        @(negedge clk);
        bus_rd(2'd0, d);
        chk("R6 collided byte", d, 8'h22);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_write_ack();
        t_strobe();
        t_ctrl();
        t_intr_in();
        t_intr_out();
        t_status();
        t_collision();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule